// File: doc/BRIEF.md
# Address-Obfuscating Shuffle Buffer Controller

This controller sits between a processor-side block request port and an external memory bus. Its purpose is to hide program control flow. Without it, the sequence of block addresses on the bus would show which blocks the program visits, and in what order. The controller keeps a small on-chip buffer of whole memory blocks. It also keeps a remapping table that records, for every logical block, the physical memory slot that currently holds it.

A request for a block already in the buffer is answered from on-chip storage and causes no bus activity. A request for any other block reads that block from the physical slot the table gives. Until the buffer has been filled once, the block simply lands in an empty entry. After that, a pseudo-random victim is chosen. The victim is never the entry filled by the most recent miss. The victim is written into the slot the fetch has just freed, and the table is updated. As a result, blocks keep changing physical addresses and no block is written back to where it came from.

Only one miss is in flight at a time. While a miss is in flight, `busy` is high and new requests are not accepted. The bus uses three independent single-beat valid/ready channels: read address, read data and write.

Top module: `shuffle_obf`

## Requirements
- R1: For at least one cycle after reset is released, `busy`, `rsp_valid`, `ar_valid` and `w_valid` are low. Every buffer entry starts empty. The remapping table starts as the identity, so the first fetch of block b after reset reads physical address b.
- R2: A request accepted for a block that is in the buffer gets `rsp_valid` in the next cycle, carrying that block's data. The request starts no bus transaction and `busy` stays low.
- R3: While at least one buffer entry is empty, a miss performs exactly one read and no write. The block is placed in the lowest-numbered empty entry.
- R4: Once every entry is valid, each miss performs exactly one read followed by exactly one write. The write address equals the read address of the same miss. The write data is the content of a block that was in the buffer and is not the requested block.
- R5: Every bus read address equals the slot where the requested block was last written, or the block's own number if it has never been written since reset. Every response carries the requested block's own content. A block's "in buffer" table flag agrees with the buffer tag lookup.
- R6: The victim of a replacement is never the entry filled by the most recent miss. Hits do not change which entry that is.
- R7: `busy` is high from the cycle after a miss is accepted until the cycle its response appears. A request presented while `busy` is high is ignored: it produces no response and no bus read.
- R8: `ar_valid` and `w_valid` stay high until their ready is seen, and address and data stay stable while they wait. `r_ready` is high only while read data is awaited.
- R9: At most one of `ar_valid`, `r_ready` and `w_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Block request; taken in a cycle where `busy` is low |
| req_blk | input | 6 | Logical block number requested |
| busy | output | 1 | Miss in flight; requests are ignored |
| rsp_valid | output | 1 | One-cycle pulse: response data valid |
| rsp_data | output | 32 | Content of the requested block |
| ar_valid | output | 1 | Read address valid |
| ar_addr | output | 6 | Physical slot to read |
| ar_ready | input | 1 | Memory accepts read address |
| r_valid | input | 1 | Read data valid |
| r_data | input | 32 | Read data |
| r_ready | output | 1 | Controller waits for read data |
| w_valid | output | 1 | Write request valid |
| w_addr | output | 6 | Physical slot to write |
| w_data | output | 32 | Evicted block content |
| w_ready | input | 1 | Memory accepts the write |

## Verification
The assertions check the following on every cycle:
- hits stay off the bus and are answered on the next cycle;
- no write is issued while an entry is still empty;
- a waiting read-address or write request holds its address and data;
- the bus phases never overlap;
- a victim never equals the most recently filled entry;
- the table's residency flag agrees with the tag lookup.

Some properties only show over whole request sequences in the bench, which keeps its own memory image and slot map:
- every read goes to where the block was last written;
- every response returns the block's own content through many relocations;
- the evicted block is a resident block other than the requested one and the previous miss;
- requests made while busy leave no trace.

// File: rtl/sbuf_pkg.sv
// Package: shared state encoding for the shuffle buffer controller.
// Assumes: one miss in flight at a time; states are visited in declared order
// except that a miss skips victim selection while the buffer still has room.
package sbuf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a request; hits are served here
        ST_RADDR,   // read address offered on the bus
        ST_RDATA,   // waiting for read data
        ST_PICK,    // drawing a victim that is not the last filled entry
        ST_WRITE,   // victim written into the slot just read
        ST_INST     // install the fetched block and respond
    } sbuf_state_t;
endpackage

// File: rtl/sbuf_lfsr.sv
// Module: free-running Galois LFSR used as the victim index source.
// Assumes: TAPS describes a maximal-length polynomial for width W and SEED is
// nonzero; only the low IW bits are used, so ENTRIES must be a power of two.
module sbuf_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] TAPS = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1,
    parameter int          IW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [IW-1:0] rnd
);
    logic [W-1:0] state_q;

    // Advance the generator every cycle; reseed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED[W-1:0];
        else        state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS[W-1:0] : '0);
    end

    assign rnd = state_q[IW-1:0];
endmodule

// File: rtl/sbuf_remap.sv
// Module: remapping table, one entry per logical block holding its current
// physical slot and a flag that says the block is held on chip.
// Assumes: the two write ports never address the same block in one cycle.
module sbuf_remap #(
    parameter int NBLK = 64,
    parameter int SW   = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] rd_blk,
    output logic [SW-1:0] rd_slot,
    output logic          rd_onchip,
    input  logic          in_en,     // block moves on chip
    input  logic [SW-1:0] in_blk,
    input  logic          out_en,    // block leaves to a new slot
    input  logic [SW-1:0] out_blk,
    input  logic [SW-1:0] out_slot
);
    logic [SW-1:0] slot_q   [NBLK];
    logic          onchip_q [NBLK];

    // Identity mapping at reset; update residency and slot on a swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) begin
                slot_q[i]   <= SW'(i);
                onchip_q[i] <= 1'b0;
            end
        end else begin
            if (in_en) onchip_q[in_blk] <= 1'b1;
            if (out_en) begin
                onchip_q[out_blk] <= 1'b0;
                slot_q[out_blk]   <= out_slot;
            end
        end
    end

    assign rd_slot   = slot_q[rd_blk];
    assign rd_onchip = onchip_q[rd_blk];
endmodule

// File: rtl/sbuf_store.sv
// Module: shuffle buffer storage, holding tags, data and valid bits.
// Provides a tag lookup, the lowest empty entry, and a read port for the
// victim.
// Assumes: tags are unique among valid entries (the controller guarantees it).
module sbuf_store #(
    parameter int ENTRIES = 8,
    parameter int TW      = 6,
    parameter int DW      = 32,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] lk_tag,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data,
    output logic [IW-1:0] free_idx,
    output logic          full,
    input  logic [IW-1:0] rd_idx,
    output logic [TW-1:0] rd_tag,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag,
    input  logic [DW-1:0] wr_data
);
    logic [TW-1:0] tag_q  [ENTRIES];
    logic [DW-1:0] data_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;

    // Clear valid bits on reset; write one entry on install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx]  <= 1'b1;
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Fully associative tag match across all entries.
    always_comb begin
        lk_hit  = 1'b0;
        lk_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld_q[i] && tag_q[i] == lk_tag) begin
                lk_hit  = 1'b1;
                lk_data = data_q[i];
            end
        end
    end

    // Lowest-numbered empty entry (scan from the top so the lowest wins).
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IW'(i);
        end
    end

    assign full    = &vld_q;
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/shuffle_obf.sv
// Module: address-obfuscating shuffle buffer controller (top).
// Hits are answered from the buffer on the next cycle. A miss reads the
// block from the slot the remapping table names. Once the buffer is full, the
// miss then writes a random victim (never the last filled entry) into that
// same slot and re-points the victim's table entry before installing.
// Assumes: ENTRIES is a power of two; memory answers each read with one beat.
module shuffle_obf #(
    parameter int ENTRIES = 8,
    parameter int NBLK    = 64,
    parameter int DW      = 32,
    parameter int LW      = 16,
    localparam int BW     = $clog2(NBLK),
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [BW-1:0] req_blk,
    output logic          busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          ar_valid,
    output logic [BW-1:0] ar_addr,
    input  logic          ar_ready,
    input  logic          r_valid,
    input  logic [DW-1:0] r_data,
    output logic          r_ready,
    output logic          w_valid,
    output logic [BW-1:0] w_addr,
    output logic [DW-1:0] w_data,
    input  logic          w_ready
);
    import sbuf_pkg::*;

    sbuf_state_t   state_q;
    logic [BW-1:0] blk_q, slot_q;
    logic [DW-1:0] fetch_q;
    logic [IW-1:0] victim_q, last_ins_q;
    logic          repl_q;

    logic          lk_hit, tbl_onchip, buf_full;
    logic [DW-1:0] lk_data, v_data;
    logic [BW-1:0] tbl_slot, v_tag;
    logic [IW-1:0] free_idx, rnd;
    logic          accept, install;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign install = (state_q == ST_INST);

    sbuf_lfsr #(.W(LW), .IW(IW)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    sbuf_remap #(.NBLK(NBLK), .SW(BW)) u_remap (
        .clk(clk), .rst_n(rst_n),
        .rd_blk(req_blk), .rd_slot(tbl_slot), .rd_onchip(tbl_onchip),
        .in_en(install), .in_blk(blk_q),
        .out_en(install && repl_q), .out_blk(v_tag), .out_slot(slot_q)
    );

    sbuf_store #(.ENTRIES(ENTRIES), .TW(BW), .DW(DW), .IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_tag(req_blk), .lk_hit(lk_hit), .lk_data(lk_data),
        .free_idx(free_idx), .full(buf_full),
        .rd_idx(victim_q), .rd_tag(v_tag), .rd_data(v_data),
        .wr_en(install), .wr_idx(victim_q), .wr_tag(blk_q), .wr_data(fetch_q)
    );

    // Miss sequencer together with the hit response path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            blk_q      <= '0;
            slot_q     <= '0;
            fetch_q    <= '0;
            victim_q   <= '0;
            last_ins_q <= '0;
            repl_q     <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    if (lk_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= lk_data;
                    end else begin
                        blk_q   <= req_blk;
                        slot_q  <= tbl_slot;
                        state_q <= ST_RADDR;
                    end
                end
                ST_RADDR: if (ar_ready) state_q <= ST_RDATA;
                ST_RDATA: if (r_valid) begin
                    fetch_q <= r_data;
                    if (buf_full) begin
                        state_q <= ST_PICK;
                    end else begin
                        victim_q <= free_idx;
                        repl_q   <= 1'b0;
                        state_q  <= ST_INST;
                    end
                end
                ST_PICK: if (rnd != last_ins_q) begin
                    victim_q <= rnd;
                    repl_q   <= 1'b1;
                    state_q  <= ST_WRITE;
                end
                ST_WRITE: if (w_ready) state_q <= ST_INST;
                ST_INST: begin
                    last_ins_q <= victim_q;
                    rsp_valid  <= 1'b1;
                    rsp_data   <= fetch_q;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign ar_valid = (state_q == ST_RADDR);
    assign ar_addr  = slot_q;
    assign r_ready  = (state_q == ST_RDATA);
    assign w_valid  = (state_q == ST_WRITE);
    assign w_addr   = slot_q;
    assign w_data   = v_data;
endmodule

// File: rtl/shuffle_obf_chk.sv
// Module: property checker bound to shuffle_obf.
// It watches the ports and the signals passed between the table, the buffer
// store and the sequencer.
module shuffle_obf_chk #(
    parameter int BW = 6,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          accept,
    input logic          lk_hit,
    input logic          tbl_onchip,
    input logic          buf_full,
    input logic          rsp_valid,
    input logic          busy,
    input logic          ar_valid,
    input logic          ar_ready,
    input logic [BW-1:0] ar_addr,
    input logic          r_ready,
    input logic          w_valid,
    input logic          w_ready,
    input logic [BW-1:0] w_addr,
    input logic [IW-1:0] victim_q,
    input logic [IW-1:0] last_ins_q
);
    // R2: a hit is answered next cycle without starting a bus read
    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && lk_hit |=> rsp_valid && !ar_valid);

    // R3: no write while the buffer still has an empty entry
    p_fill_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> buf_full);

    // R5: table residency flag agrees with the buffer tag lookup
    p_tag_table_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (lk_hit == tbl_onchip));

    // R6: victim differs from the entry filled by the last miss
    p_victim_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> (victim_q != last_ins_q));

    // R7: a response is only given with the controller idle
    p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    // R8: read address held stable until accepted
    p_ar_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr));

    // R8: write held stable until accepted
    p_w_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && !w_ready |=> w_valid && $stable(w_addr));

    // R9: bus phases never overlap
    p_one_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ar_valid, r_ready, w_valid}));
endmodule

bind shuffle_obf shuffle_obf_chk #(.BW(BW), .IW(IW)) i_chk (
    .clk(clk), .rst_n(rst_n), .accept(accept), .lk_hit(lk_hit),
    .tbl_onchip(tbl_onchip), .buf_full(buf_full), .rsp_valid(rsp_valid),
    .busy(busy), .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .r_ready(r_ready), .w_valid(w_valid), .w_ready(w_ready), .w_addr(w_addr),
    .victim_q(victim_q), .last_ins_q(last_ins_q)
);

// File: tb/test_shuffle_obf.sv
`timescale 1ns/1ps
module test_shuffle_obf;
    localparam int NE = 8;
    localparam int NB = 64;
    localparam logic [31:0] BASE = 32'hB10C_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_blk = '0;
    logic        busy, rsp_valid, ar_valid, r_ready, w_valid;
    logic [31:0] rsp_data, w_data;
    logic [5:0]  ar_addr, w_addr;
    logic        ar_ready = 1'b0, r_valid = 1'b0, w_ready = 1'b0;
    logic [31:0] r_data = '0;

    always #2.5 clk = ~clk;

    shuffle_obf i_shuffle_obf (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .ar_valid(ar_valid), .ar_addr(ar_addr), .ar_ready(ar_ready),
        .r_valid(r_valid), .r_data(r_data), .r_ready(r_ready),
        .w_valid(w_valid), .w_addr(w_addr), .w_data(w_data), .w_ready(w_ready)
    );

    int errors = 0, checks = 0;
    // Bench model: memory image, where each block lives, residency.
    logic [31:0] bmem [NB];
    int  where_blk [NB];
    bit  res [NB];
    int  nres, cur_req, prev_ins, rd_cnt, wr_cnt, jit;
    bit  stall, ar_wait, w_wait, rd_pend;
    logic [5:0]  ar_seen, w_seen, rd_addr;
    logic [31:0] w_seen_d;

    function automatic logic [31:0] word_of(int b);
        return BASE + 32'(b);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        for (int i = 0; i < NB; i++) begin
            bmem[i] = word_of(i);
            where_blk[i] = i;
            res[i] = 1'b0;
        end
        nres = 0; prev_ins = -1; cur_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk(!busy && !rsp_valid && !ar_valid && !w_valid, "R1 idle after reset",
            {busy, rsp_valid, ar_valid, w_valid}, 0);
    endtask

    // Bus responder: handshakes resolved on the negedge after the posedge.
    initial begin
        forever begin
            @(negedge clk);
            jit++;
            if (!rst_n) begin
                ar_ready = 0; r_valid = 0; w_ready = 0;
                ar_wait = 0; w_wait = 0; rd_pend = 0;
                continue;
            end
            if (ar_valid || r_ready || w_valid)
                chk($countones({ar_valid, r_ready, w_valid}) == 1, "R9 one phase",
                    $countones({ar_valid, r_ready, w_valid}), 1);
            // read address channel
            if (ar_ready) begin
                ar_ready = 0; ar_wait = 0; rd_cnt++; rd_addr = ar_seen; rd_pend = 1;
                chk(int'(ar_seen) == where_blk[cur_req], "R5 read slot", ar_seen, where_blk[cur_req]);
            end else if (ar_valid) begin
                if (ar_wait) chk(ar_addr == ar_seen, "R8 ar stable", ar_addr, ar_seen);
                ar_seen = ar_addr; ar_wait = 1;
                if (!stall || jit % 3 == 0) ar_ready = 1;
            end
            // read data channel
            if (r_valid) begin
                r_valid = 0;
            end else if (rd_pend && r_ready && (!stall || jit % 2 == 0)) begin
                r_valid = 1; r_data = bmem[rd_addr]; rd_pend = 0;
            end
            // write channel
            if (w_ready) begin
                int v;
                w_ready = 0; w_wait = 0; wr_cnt++;
                v = int'(w_seen_d - BASE);
                chk(nres >= NE, "R3 no write while filling", nres, NE);
                chk(w_seen == rd_addr, "R4 write to read slot", w_seen, rd_addr);
                chk(v >= 0 && v < NB && v != cur_req && res[v] == 1'b1, "R4 victim resident", v, -1);
                chk(v != prev_ins, "R6 victim not last filled", v, prev_ins);
                bmem[w_seen] = w_seen_d;
                if (v >= 0 && v < NB) begin
                    where_blk[v] = int'(w_seen);
                    res[v] = 1'b0;
                end
            end else if (w_valid) begin
                if (w_wait) chk(w_addr == w_seen && w_data == w_seen_d, "R8 w stable", w_addr, w_seen);
                w_seen = w_addr; w_seen_d = w_data; w_wait = 1;
                if (!stall || jit % 3 == 1) w_ready = 1;
            end
        end
    end

    task automatic do_req(int b, bit junk);
        int lat, rd0, wr0;
        bit exp_hit;
        @(negedge clk);
        exp_hit = res[b];
        cur_req = b; rd0 = rd_cnt; wr0 = wr_cnt;
        req_valid = 1'b1; req_blk = 6'(b);
        @(negedge clk);
        lat = 1;
        while (!rsp_valid && lat < 300) begin
            req_valid = junk;                 // R7: offered while busy
            req_blk = 6'((b + 1) % NB);
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        chk(rsp_data == word_of(b), "R5 response data", rsp_data, word_of(b));
        if (exp_hit) begin
            chk(lat == 1 && rd_cnt == rd0 && wr_cnt == wr0, "R2 hit one cycle no bus", lat, 1);
        end else begin
            chk(lat > 1 && rd_cnt == rd0 + 1, "R5 one read per miss", rd_cnt - rd0, 1);
            chk(wr_cnt == wr0 + ((nres >= NE) ? 1 : 0), "R3 R4 write count",
                wr_cnt - wr0, (nres >= NE) ? 1 : 0);
            res[b] = 1'b1;
            if (nres < NE) nres++;
            prev_ins = b;
        end
        if (junk) begin
            rd0 = rd_cnt;
            repeat (3) begin
                @(negedge clk);
                chk(!rsp_valid && !busy, "R7 busy request ignored", rsp_valid, 0);
            end
            chk(rd_cnt == rd0, "R7 no read from ignored request", rd_cnt - rd0, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rd_cnt = 0; wr_cnt = 0; jit = 0; stall = 0;
        do_reset();
        // R1 R3: fill phase, first reads at identity addresses
        for (int i = 0; i < NE; i++) do_req((i * 9) % NB, 1'b0);
        // R2: every resident block hits
        for (int i = 0; i < NE; i++) do_req((i * 9) % NB, 1'b0);
        // R7: miss with requests offered while busy
        do_req(5, 1'b1);
        // R4 R5 R6: replacement sweep under bus stalls with repeated accesses
        stall = 1;
        for (int i = 0; i < 400; i++) begin
            int b;
            b = (i * 23 + i / 64) % NB;
            do_req(b, 1'b0);
            if (i % 4 == 0) do_req(b, 1'b0);
            if (i % 7 == 0) do_req((b + 1) % NB, 1'b0);
        end
        // R1: reset restores identity mapping and empty buffer
        do_reset();
        stall = 0;
        for (int i = 0; i < 3 * NB; i++) do_req(i % NB, (i % 50) == 10);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule